// File: doc/BRIEF.md
# Single-Bus Accumulator Add Sequencer

This block adds one memory operand to an accumulator, using a datapath in which every register transfer crosses one shared internal bus. A start strobe captures the operand address. A step counter then walks five single-cycle steps. The first step moves the address into the memory address register. The second reads memory into the buffer register. The third moves the buffer into the Y staging register. The fourth has the ALU add Y to the accumulator, which is the only value on the bus in that step, and places the sum with its carry and zero flags in the Z register. The fifth writes Z back into the accumulator.

Each step decodes to a set of load enables and exactly one bus driver enable. A controller outside the block issues start and collects the done pulse. Memory is a simple read port: the address and read strobe leave the block in the second step, and the data must be valid before the clock edge that ends that step.

Top module: `acc_add_seq`

## Requirements
- R1: While reset is low, and until the first operation completes after it, `acc_o` is 0. `done_o`, `mem_rd_o`, `carry_o` and `zero_o` are 0 while reset is low.
- R2: A start sampled high while idle, or in the done cycle, begins an operation. `done_o` is high for exactly one cycle: the fifth cycle after the edge that sampled start, which is 4 edges later.
- R3: `acc_o` changes only on the edge that ends the done cycle. It then takes the value (previous `acc_o` + memory word) modulo 2^DATA_W.
- R4: `mem_rd_o` is high for exactly one cycle per operation: the second cycle, 3 cycles before `done_o`. During that cycle `mem_addr_o` equals the address captured with start.
- R5: A start sampled during the first four steps of a running operation is ignored. It yields no extra read, no extra done and no extra addition.
- R6: After an operation, `carry_o` holds the carry out of the addition and `zero_o` is 1 exactly when the DATA_W-bit sum is 0. Both keep their values until the next operation's add step.
- R7: In every cycle at most one source drives the internal bus.
- R8: `opaddr_i` is sampled only on the edge that accepts start. Changes to it later in the operation do not affect the read address.
- R9: A start given in the done cycle begins the next operation with no idle cycle between, and it adds to the just-updated accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin an add operation |
| opaddr_i | input | ADDR_W | Operand address, captured with start |
| mem_addr_o | output | ADDR_W | Memory read address (memory address register) |
| mem_rd_o | output | 1 | Memory read strobe, high in step two |
| mem_data_i | input | DATA_W | Memory read data, valid in the strobe cycle |
| done_o | output | 1 | One-cycle completion pulse in step five |
| acc_o | output | DATA_W | Accumulator value |
| carry_o | output | 1 | Carry out of the last addition |
| zero_o | output | 1 | Last sum was zero |

## Verification
The bench counts clock edges. Call the edge that samples start edge k. Then the read strobe is due in the cycle after edge k+1, the done pulse in the cycle after edge k+4, and the new accumulator and flags in the cycle after edge k+5. The driver records the expected done cycle with each item it queues. The monitor samples on falling edges, checks the read address and cycle against the queue head when the strobe appears, and pops the head on done. It compares the accumulator and flags one falling edge later. At the end, the counts of reads and done pulses must match the number of accepted starts, which is how ignored starts are caught.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_T4   = 3'd4,
    ST_T5   = 3'd5
  } step_e;

  // bus source indices
  localparam int SRC_IRA = 0;
  localparam int SRC_MEM = 1;
  localparam int SRC_MBR = 2;
  localparam int SRC_AC  = 3;
  localparam int SRC_Z   = 4;
  localparam int NSRC    = 5;

  typedef struct packed {
    logic [NSRC-1:0] drv;
    logic            ld_mar;
    logic            ld_mbr;
    logic            ld_y;
    logic            ld_z;
    logic            ld_ac;
    logic            mem_rd;
    logic            done;
  } ctrl_t;

endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/seq_step_ctr.sv
module seq_step_ctr
  import acc_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  output step_e step_o,
  output logic  accept_o
);
  step_e step_q, step_d;

  assign accept_o = start_i && ((step_q == ST_IDLE) || (step_q == ST_T5));

  always_comb begin
    step_d = step_q;
    case (step_q)
      ST_IDLE: if (start_i) step_d = ST_T1;
      ST_T1:   step_d = ST_T2;
      ST_T2:   step_d = ST_T3;
      ST_T3:   step_d = ST_T4;
      ST_T4:   step_d = ST_T5;
      ST_T5:   step_d = start_i ? ST_T1 : ST_IDLE;
      default: step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= ST_IDLE;
    else        step_q <= step_d;
  end

  assign step_o = step_q;
endmodule

// File: rtl/seq_ctrl_decode.sv
module seq_ctrl_decode
  import acc_seq_pkg::*;
(
  input  step_e step_i,
  output ctrl_t ctl_o
);
  always_comb begin
    ctl_o = '0;
    case (step_i)
      ST_T1: begin
        ctl_o.drv[SRC_IRA] = 1'b1;
        ctl_o.ld_mar       = 1'b1;
      end
      ST_T2: begin
        ctl_o.drv[SRC_MEM] = 1'b1;
        ctl_o.mem_rd       = 1'b1;
        ctl_o.ld_mbr       = 1'b1;
      end
      ST_T3: begin
        ctl_o.drv[SRC_MBR] = 1'b1;
        ctl_o.ld_y         = 1'b1;
      end
      ST_T4: begin
        ctl_o.drv[SRC_AC]  = 1'b1;
        ctl_o.ld_z         = 1'b1;
      end
      ST_T5: begin
        ctl_o.drv[SRC_Z]   = 1'b1;
        ctl_o.ld_ac        = 1'b1;
        ctl_o.done         = 1'b1;
      end
      default: ctl_o = '0;
    endcase
  end
endmodule

// File: rtl/seq_bus_mux.sv
module seq_bus_mux #(
  parameter int W = 8,
  parameter int N = 5
) (
  input  logic [N-1:0][W-1:0] src_i,
  input  logic [N-1:0]        en_i,
  output logic [W-1:0]        bus_o
);
  logic [N:0][W-1:0] acc;

  assign acc[0] = '0;
  for (genvar i = 0; i < N; i++) begin : g_drv
    assign acc[i+1] = acc[i] | (src_i[i] & {W{en_i[i]}});
  end
  assign bus_o = acc[N];
endmodule

// File: rtl/seq_alu_add.sv
module seq_alu_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         zero_o
);
  logic [W:0] full;

  assign full    = {1'b0, a_i} + {1'b0, b_i};
  assign sum_o   = full[W-1:0];
  assign carry_o = full[W];
  assign zero_o  = (full[W-1:0] == '0);
endmodule

// File: rtl/acc_add_seq.sv
module acc_add_seq
  import acc_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] opaddr_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              done_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              carry_o,
  output logic              zero_o
);
  logic        rst_q_n;
  step_e       step;
  logic        accept;
  ctrl_t       ctl;
  logic [NSRC-1:0] drv_en;

  logic [ADDR_W-1:0] ira_q;
  logic [ADDR_W-1:0] mar_q;
  logic [DATA_W-1:0] mbr_q, y_q, z_q, ac_q;
  logic              zc_q, zz_q;

  logic [DATA_W-1:0] ira_ext;
  logic [DATA_W-1:0] bus;
  logic [NSRC-1:0][DATA_W-1:0] srcs;
  logic [DATA_W-1:0] alu_sum;
  logic              alu_c, alu_z;

  seq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_o(rst_q_n));

  seq_step_ctr u_ctr (
    .clk(clk), .rst_n(rst_q_n), .start_i(start_i),
    .step_o(step), .accept_o(accept)
  );

  seq_ctrl_decode u_dec (.step_i(step), .ctl_o(ctl));
  assign drv_en = ctl.drv;

  always_comb begin
    ira_ext             = '0;
    ira_ext[ADDR_W-1:0] = ira_q;
  end

  always_comb begin
    srcs          = '0;
    srcs[SRC_IRA] = ira_ext;
    srcs[SRC_MEM] = mem_data_i;
    srcs[SRC_MBR] = mbr_q;
    srcs[SRC_AC]  = ac_q;
    srcs[SRC_Z]   = z_q;
  end

  seq_bus_mux #(.W(DATA_W), .N(NSRC)) u_bus (
    .src_i(srcs), .en_i(drv_en), .bus_o(bus)
  );

  // Y on one input, bus (carrying AC in step four) on the other
  seq_alu_add #(.W(DATA_W)) u_alu (
    .a_i(y_q), .b_i(bus), .sum_o(alu_sum), .carry_o(alu_c), .zero_o(alu_z)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) ira_q <= '0;
    else if (accept) ira_q <= opaddr_i;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) mar_q <= '0;
    else if (ctl.ld_mar) mar_q <= bus[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) mbr_q <= '0;
    else if (ctl.ld_mbr) mbr_q <= bus;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) y_q <= '0;
    else if (ctl.ld_y) y_q <= bus;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      z_q  <= '0;
      zc_q <= 1'b0;
      zz_q <= 1'b0;
    end else if (ctl.ld_z) begin
      z_q  <= alu_sum;
      zc_q <= alu_c;
      zz_q <= alu_z;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) ac_q <= '0;
    else if (ctl.ld_ac) ac_q <= bus;
  end

  assign mem_addr_o = mar_q;
  assign mem_rd_o   = ctl.mem_rd;
  assign done_o     = ctl.done;
  assign acc_o      = ac_q;
  assign carry_o    = zc_q;
  assign zero_o     = zz_q;
endmodule

// File: rtl/acc_add_seq_chk.sv
module acc_add_seq_chk
  import acc_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   drv_en,
  input logic              done_o,
  input logic              mem_rd_o,
  input logic [DATA_W-1:0] acc_o
);
  AST_ONE_BUS_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drv_en)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R2

  AST_READ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> !mem_rd_o); // R4

  AST_READ_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(mem_rd_o, 3)); // R4

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> $stable(acc_o)); // R3
endmodule

bind acc_add_seq acc_add_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .drv_en(drv_en),
  .done_o(done_o), .mem_rd_o(mem_rd_o), .acc_o(acc_o)
);

// File: tb/acc_add_seq_test.sv
module acc_add_seq_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [7:0] opaddr_i;
  logic [7:0] mem_addr_o;
  logic       mem_rd_o;
  logic [7:0] mem_data_i;
  logic       done_o;
  logic [7:0] acc_o;
  logic       carry_o, zero_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pushes = 0, dones = 0, reads = 0;
  bit live = 0;
  bit finished = 0;
  logic [7:0] model_acc = 8'd0;

  typedef struct {
    logic [7:0] addr;
    logic [7:0] acc;
    logic       c;
    logic       z;
    int         done_cyc;
  } exp_t;
  exp_t q[$];
  exp_t cur;
  bit pend = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] memv(input logic [7:0] a);
    logic [15:0] p;
    p = a * 16'd37 + 16'd11;
    return p[7:0];
  endfunction

  assign mem_data_i = mem_rd_o ? memv(mem_addr_o) : 8'hA5;

  acc_add_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .opaddr_i(opaddr_i),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_data_i(mem_data_i),
    .done_o(done_o), .acc_o(acc_o), .carry_o(carry_o), .zero_o(zero_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // driver: call just after a falling edge
  task automatic issue(input logic [7:0] a);
    logic [8:0] s;
    exp_t e;
    start_i  = 1'b1;
    opaddr_i = a;
    @(posedge clk); #1;
    start_i  = 1'b0;
    opaddr_i = ~a;                       // R8: later changes must be ignored
    s = {1'b0, model_acc} + {1'b0, memv(a)};
    e.addr = a; e.acc = s[7:0]; e.c = s[8]; e.z = (s[7:0] == 8'd0);
    e.done_cyc = cyc + 4;
    model_acc = s[7:0];
    q.push_back(e);
    pushes++;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (live) begin
      if (pend) begin
        chk(acc_o == cur.acc, "R3 accumulator", acc_o, cur.acc);
        chk(carry_o == cur.c, "R6 carry", carry_o, cur.c);
        chk(zero_o == cur.z, "R6 zero", zero_o, cur.z);
        pend = 0;
      end
      if (mem_rd_o) begin
        reads++;
        if (q.size() == 0) chk(0, "R5 unexpected read", 1, 0);
        else begin
          chk(mem_addr_o == q[0].addr, "R4/R8 read address", mem_addr_o, q[0].addr);
          chk(cyc == q[0].done_cyc - 3, "R4 read cycle", cyc, q[0].done_cyc - 3);
        end
      end
      if (done_o) begin
        dones++;
        if (q.size() == 0) chk(0, "R5 unexpected done", 1, 0);
        else begin
          cur = q.pop_front();
          chk(cyc == cur.done_cyc, "R2 done cycle", cyc, cur.done_cyc);
          pend = 1;
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog act=hung exp=finished");
    summary();
  end

  initial begin
    logic [7:0] za;
    rst_n = 1'b0; start_i = 1'b0; opaddr_i = 8'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(acc_o == 8'd0, "R1 acc reset", acc_o, 0);
    chk(done_o == 1'b0, "R1 done reset", done_o, 0);
    chk(mem_rd_o == 1'b0, "R1 read reset", mem_rd_o, 0);
    chk(carry_o == 1'b0, "R1 carry reset", carry_o, 0);
    chk(zero_o == 1'b0, "R1 zero reset", zero_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(acc_o == 8'd0, "R1 acc after release", acc_o, 0);
    live = 1;

    // R2 R3 R4 R6: single operations, varied addresses
    issue(8'h03); settle();
    issue(8'h40); settle();
    issue(8'hC7); settle();
    issue(8'hFF); settle();

    // R6: force a zero sum
    za = 8'd0;
    for (int i = 0; i < 256; i++)
      if (memv(i[7:0]) == 8'(8'd0 - model_acc)) za = i[7:0];
    issue(za); settle();
    chk(acc_o == 8'd0, "R6 zero sum acc", acc_o, 0);
    chk(zero_o == 1'b1, "R6 zero flag", zero_o, 1);

    // R5: starts while busy are ignored
    issue(8'h21);
    @(negedge clk);
    start_i = 1'b1; opaddr_i = 8'h99;
    repeat (2) @(negedge clk);
    start_i = 1'b0;
    settle();
    chk(dones == pushes, "R5 done count", dones, pushes);
    chk(reads == pushes, "R5 read count", reads, pushes);

    // R9: back-to-back operations
    issue(8'h10);
    for (int k = 0; k < 3; k++) begin
      do @(negedge clk); while (!done_o);
      issue(8'h11 + k[7:0]);
    end
    settle();

    chk(q.size() == 0, "R9 queue drained", q.size(), 0);
    chk(dones == pushes, "R9 done count", dones, pushes);
    chk(reads == pushes, "R4 read count", reads, pushes);
    chk(acc_o == model_acc, "R9 final acc", acc_o, model_acc);
    summary();
  end
endmodule